// File: doc/BRIEF.md
# NAND Bus Strobe Timing Generator

This block produces the chip-enable, write-strobe and read-strobe waveforms of an 8-bit NAND flash bus for one byte transfer at a time. All phase lengths come from one packed 32-bit timing word: a lead time from chip-enable to the first strobe, separate low and high strobe phases for reads and writes, a bus turnaround gap, and a delay before the ready/busy line is trusted after a command that starts an internal flash operation.

A sequencer above it presents one transfer per handshake (`req_valid` while `req_ready` is high), with a direction bit, a flag saying the flash goes busy afterwards, and the write byte. The block drives the data bus only for writes, captures the read byte at the end of the read-strobe low phase, and pulses `xfer_done` when the transfer, including any busy wait, has finished. Chip-enable stays low across transfers until the sequencer raises `op_end` while the block is idle.

Every field value N gives a phase of N+1 clock cycles, so an all-zero word is the fastest legal setting.

Top module: `nand_strobe_gen`

## Requirements
- R1: A write transfer (req_dir = 0) drives nand_we_n low for WL+1 cycles and then holds it high for WH+1 cycles, with WL in bits [3:0] and WH in bits [7:4] of cfg_word. With no lead time and no gap due, nand_we_n is low in the first cycle after acceptance.
- R2: A read transfer (req_dir = 1) drives nand_re_n low for RL+1 cycles and then high for RH+1 cycles, with RL in bits [11:8] and RH in bits [15:12]. The two strobes are never low together.
- R3: rd_data takes the value on nand_dq_in at the clock edge that ends the last read-strobe low cycle, shows it from the next cycle on, and keeps it until the next read capture.
- R4: nand_dq_oe is high, and nand_dq_out carries the accepted write byte, exactly during the low and high phases of a write. nand_dq_oe stays low for reads.
- R5: When a transfer's direction differs from that of the previous completed transfer, TA+1 quiet cycles (TA in bits [18:16]) come before its strobe goes low. No gap is inserted for the same direction or for the first transfer after reset.
- R6: A request accepted while chip-enable is released pulls nand_ce_n low in the next cycle and waits CEA+1 cycles (CEA in bits [25:24]) before any gap or strobe phase.
- R7: A transfer with req_busy = 1 waits BSY+1 cycles (BSY in bits [23:19]) after its high phase, during which nand_rb is ignored.
- R8: After that delay the block waits until nand_rb is sampled high (1 = ready). The transfer then completes in the following cycle.
- R9: nand_ce_n stays low between transfers and is released only in the cycle after op_end is seen while idle. A strobe is never low while nand_ce_n is high.
- R10: xfer_done is a one-cycle pulse in the first cycle after a transfer completes. That is the cycle after the high phase ends, or the cycle after nand_rb is sampled ready for a busy transfer. The block is idle in that cycle.
- R11: req_ready is high only while idle with op_end low. When op_end and req_valid are both high in an idle cycle, op_end wins: the request waits, chip-enable is released, and the request is then taken with a fresh lead time.
- R12: Reset leaves nand_ce_n, nand_we_n and nand_re_n high, nand_dq_oe and xfer_done low, rd_data zero and req_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed timing word |
| req_valid | input | 1 | Transfer request |
| req_dir | input | 1 | 0 = write, 1 = read |
| req_busy | input | 1 | Flash goes busy after this transfer |
| req_wdata | input | 8 | Byte to write |
| op_end | input | 1 | Close the current operation, release chip-enable |
| req_ready | output | 1 | Request can be taken this cycle |
| xfer_done | output | 1 | Transfer finished pulse |
| rd_data | output | 8 | Last byte read |
| nand_ce_n | output | 1 | Chip-enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb | input | 1 | Ready/busy line, 1 = ready |

## Verification
Two functions can land in the same cycle: closing an operation with op_end, and taking a new request. The bench raises both in one idle cycle after a transfer has left chip-enable low. It expects req_ready to fall at once and nand_ce_n to rise after the edge. The same request must then be taken with the full lead time counted again, and the behavioural model checks every cycle of that sequence. A second overlap is the ready/busy line reading ready during the busy-sample delay. That line must be ignored, and it is judged by where the done pulse lands.

// File: rtl/nst_pkg.sv
package nst_pkg;

  // Field positions inside the timing word (a software neighbour packs them)
  localparam int WR_LO_LSB = 0;
  localparam int WR_HI_LSB = 4;
  localparam int RD_LO_LSB = 8;
  localparam int RD_HI_LSB = 12;
  localparam int TURN_LSB  = 16;
  localparam int BUSY_LSB  = 19;
  localparam int LEAD_LSB  = 24;

  localparam int STROBE_W = 4;
  localparam int TURN_W   = 3;
  localparam int BUSY_W   = 5;
  localparam int LEAD_W   = 2;

  // Highest bit used plus one
  localparam int USED_W = LEAD_LSB + LEAD_W;
  // The phase counter must hold the widest field
  localparam int CNT_W  = BUSY_W;

  typedef struct packed {
    logic [STROBE_W-1:0] wr_lo;
    logic [STROBE_W-1:0] wr_hi;
    logic [STROBE_W-1:0] rd_lo;
    logic [STROBE_W-1:0] rd_hi;
    logic [TURN_W-1:0]   turn;
    logic [BUSY_W-1:0]   busy;
    logic [LEAD_W-1:0]   lead;
  } nst_timing_t;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_TURN  = 3'd2,
    PH_LOW   = 3'd3,
    PH_HIGH  = 3'd4,
    PH_BWAIT = 3'd5,
    PH_BPOLL = 3'd6
  } nst_phase_e;

endpackage

// File: rtl/nst_cfg_decode.sv
module nst_cfg_decode
  import nst_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic [CFG_W-1:0] cfg_word,
  output nst_timing_t      tim
);

  assign tim.wr_lo = cfg_word[WR_LO_LSB +: STROBE_W];
  assign tim.wr_hi = cfg_word[WR_HI_LSB +: STROBE_W];
  assign tim.rd_lo = cfg_word[RD_LO_LSB +: STROBE_W];
  assign tim.rd_hi = cfg_word[RD_HI_LSB +: STROBE_W];
  assign tim.turn  = cfg_word[TURN_LSB  +: TURN_W];
  assign tim.busy  = cfg_word[BUSY_LSB  +: BUSY_W];
  assign tim.lead  = cfg_word[LEAD_LSB  +: LEAD_W];

  // Spare upper bits carry no timing
  generate
    if (CFG_W > USED_W) begin : g_spare
      logic spare_unused;
      assign spare_unused = ^cfg_word[CFG_W-1:USED_W];
    end
  endgenerate

endmodule

// File: rtl/nst_phase_ctrl.sv
module nst_phase_ctrl
  import nst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  nst_timing_t tim,
  input  logic        req_valid,
  input  logic        req_dir,
  input  logic        req_busy,
  input  logic        op_end,
  input  logic        rb_ready,
  output nst_phase_e  phase,
  output logic        cur_dir,
  output logic        ce_active,
  output logic        accept,
  output logic        req_ready,
  output logic        low_last,
  output logic        xfer_done
);

  nst_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             busy_q, busy_d;
  logic             ce_q, ce_d;
  logic             prev_dir_q, prev_dir_d;
  logic             have_prev_q, have_prev_d;
  logic             done_q, done_d;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt_dec;
  logic             gap_new, gap_cur;

  function automatic logic [CNT_W-1:0] low_count(input nst_timing_t t, input logic rd);
    return rd ? CNT_W'(t.rd_lo) : CNT_W'(t.wr_lo);
  endfunction

  function automatic logic [CNT_W-1:0] high_count(input nst_timing_t t, input logic rd);
    return rd ? CNT_W'(t.rd_hi) : CNT_W'(t.wr_hi);
  endfunction

  assign cnt_zero  = (cnt_q == '0);
  assign cnt_dec   = cnt_q - 1'b1;
  assign gap_new   = have_prev_q && (prev_dir_q != req_dir);
  assign gap_cur   = have_prev_q && (prev_dir_q != dir_q);
  assign req_ready = (phase_q == PH_IDLE) && !op_end;
  assign accept    = req_ready && req_valid;

  always_comb begin
    phase_d     = phase_q;
    cnt_d       = cnt_q;
    dir_d       = dir_q;
    busy_d      = busy_q;
    ce_d        = ce_q;
    prev_dir_d  = prev_dir_q;
    have_prev_d = have_prev_q;
    done_d      = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (op_end) begin
          ce_d = 1'b0;
        end else if (req_valid) begin
          dir_d  = req_dir;
          busy_d = req_busy;
          ce_d   = 1'b1;
          if (!ce_q) begin
            phase_d = PH_LEAD;
            cnt_d   = CNT_W'(tim.lead);
          end else if (gap_new) begin
            phase_d = PH_TURN;
            cnt_d   = CNT_W'(tim.turn);
          end else begin
            phase_d = PH_LOW;
            cnt_d   = low_count(tim, req_dir);
          end
        end
      end
      PH_LEAD: begin
        if (!cnt_zero) begin
          cnt_d = cnt_dec;
        end else if (gap_cur) begin
          phase_d = PH_TURN;
          cnt_d   = CNT_W'(tim.turn);
        end else begin
          phase_d = PH_LOW;
          cnt_d   = low_count(tim, dir_q);
        end
      end
      PH_TURN: begin
        if (!cnt_zero) begin
          cnt_d = cnt_dec;
        end else begin
          phase_d = PH_LOW;
          cnt_d   = low_count(tim, dir_q);
        end
      end
      PH_LOW: begin
        if (!cnt_zero) begin
          cnt_d = cnt_dec;
        end else begin
          phase_d = PH_HIGH;
          cnt_d   = high_count(tim, dir_q);
        end
      end
      PH_HIGH: begin
        if (!cnt_zero) begin
          cnt_d = cnt_dec;
        end else begin
          prev_dir_d  = dir_q;
          have_prev_d = 1'b1;
          if (busy_q) begin
            phase_d = PH_BWAIT;
            cnt_d   = CNT_W'(tim.busy);
          end else begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      PH_BWAIT: begin
        if (!cnt_zero) begin
          cnt_d = cnt_dec;
        end else begin
          phase_d = PH_BPOLL;
        end
      end
      PH_BPOLL: begin
        if (rb_ready) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      dir_q       <= 1'b0;
      busy_q      <= 1'b0;
      ce_q        <= 1'b0;
      prev_dir_q  <= 1'b0;
      have_prev_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      cnt_q       <= cnt_d;
      dir_q       <= dir_d;
      busy_q      <= busy_d;
      ce_q        <= ce_d;
      prev_dir_q  <= prev_dir_d;
      have_prev_q <= have_prev_d;
      done_q      <= done_d;
    end
  end

  assign phase     = phase_q;
  assign cur_dir   = dir_q;
  assign ce_active = ce_q;
  assign low_last  = (phase_q == PH_LOW) && cnt_zero;
  assign xfer_done = done_q;

endmodule

// File: rtl/nst_pad_drive.sv
module nst_pad_drive
  import nst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nst_phase_e        phase,
  input  logic              cur_dir,
  input  logic              ce_active,
  input  logic              accept,
  input  logic              low_last,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ce_n,
  output logic              we_n,
  output logic              re_n,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              wdata_en, rdata_en;
  logic              in_low, in_strobe;

  assign wdata_en  = accept;
  assign rdata_en  = low_last && cur_dir;
  assign wdata_d   = wdata;
  assign rdata_d   = dq_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (wdata_en) begin
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign in_low    = (phase == PH_LOW);
  assign in_strobe = in_low || (phase == PH_HIGH);

  assign ce_n    = !ce_active;
  assign we_n    = !(in_low && !cur_dir);
  assign re_n    = !(in_low && cur_dir);
  assign dq_oe   = in_strobe && !cur_dir;
  assign dq_out  = wdata_q;
  assign rd_data = rdata_q;

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              req_valid,
  input  logic              req_dir,
  input  logic              req_busy,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              op_end,
  output logic              req_ready,
  output logic              xfer_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  nst_timing_t            tim;
  nst_phase_e             phase;
  logic                   cur_dir, ce_active, accept, low_last;

  // Reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  nst_cfg_decode #(.CFG_W(CFG_W)) u_decode (
    .cfg_word (cfg_word),
    .tim      (tim)
  );

  nst_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tim       (tim),
    .req_valid (req_valid),
    .req_dir   (req_dir),
    .req_busy  (req_busy),
    .op_end    (op_end),
    .rb_ready  (nand_rb),
    .phase     (phase),
    .cur_dir   (cur_dir),
    .ce_active (ce_active),
    .accept    (accept),
    .req_ready (req_ready),
    .low_last  (low_last),
    .xfer_done (xfer_done)
  );

  nst_pad_drive #(.DATA_W(DATA_W)) u_pads (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .phase     (phase),
    .cur_dir   (cur_dir),
    .ce_active (ce_active),
    .accept    (accept),
    .low_last  (low_last),
    .wdata     (req_wdata),
    .dq_in     (nand_dq_in),
    .ce_n      (nand_ce_n),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .dq_oe     (nand_dq_oe),
    .dq_out    (nand_dq_out),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/nst_checker.sv
module nst_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              op_end,
  input logic              req_ready,
  input logic              xfer_done,
  input logic [DATA_W-1:0] rd_data,
  input logic              nand_ce_n,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic              nand_dq_oe
);

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R2

  AST_OE_COVERS_WRITE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe); // R1

  AST_OE_NEVER_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> nand_re_n); // R4

  AST_RDATA_AT_RE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $rose(nand_re_n)); // R3

  AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R9

  AST_CE_RELEASE_BY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_ce_n) |-> $past(op_end)); // R9

  AST_CE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !nand_ce_n); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R10

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (req_ready || op_end)); // R10

  AST_READY_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_we_n && nand_re_n && !nand_dq_oe)); // R11

  AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R11

endmodule

bind nand_strobe_gen nst_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .op_end     (op_end),
  .req_ready  (req_ready),
  .xfer_done  (xfer_done),
  .rd_data    (rd_data),
  .nand_ce_n  (nand_ce_n),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_strobe_gen_tb.sv
`timescale 1ns/1ps
module nand_strobe_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic        req_valid, req_dir, req_busy, op_end, nand_rb;
  logic [7:0]  req_wdata, nand_dq_in;
  logic        req_ready, xfer_done, nand_ce_n, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  rd_data, nand_dq_out;

  always #2.5 clk = ~clk;

  nand_strobe_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_dir(req_dir), .req_busy(req_busy),
    .req_wdata(req_wdata), .op_end(op_end), .req_ready(req_ready),
    .xfer_done(xfer_done), .rd_data(rd_data), .nand_ce_n(nand_ce_n),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  // Expected content of one clock cycle
  typedef struct packed {
    logic we_n; logic re_n; logic oe; logic done; logic idle; logic poll; logic cap;
  } cyc_t;

  localparam cyc_t IDLE_C = '{we_n:1'b1, re_n:1'b1, oe:1'b0, done:1'b0, idle:1'b1, poll:1'b0, cap:1'b0};
  localparam cyc_t DONE_C = '{we_n:1'b1, re_n:1'b1, oe:1'b0, done:1'b1, idle:1'b1, poll:1'b0, cap:1'b0};
  localparam cyc_t POLL_C = '{we_n:1'b1, re_n:1'b1, oe:1'b0, done:1'b0, idle:1'b0, poll:1'b1, cap:1'b0};
  localparam cyc_t WAIT_C = '{we_n:1'b1, re_n:1'b1, oe:1'b0, done:1'b0, idle:1'b0, poll:1'b0, cap:1'b0};

  cyc_t       plan_q[$];
  cyc_t       cur;
  logic       ce_exp;
  logic       have_prev, prev_dir;
  logic [7:0] rd_exp, wd_exp;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] pack_cfg(int wl, int wh, int rl, int rh, int ta, int bsy, int cea);
    return (32'(cea) << 24) | (32'(bsy) << 19) | (32'(ta) << 16) |
           (32'(rh) << 12) | (32'(rl) << 8) | (32'(wh) << 4) | 32'(wl);
  endfunction

  function automatic int fld(int lsb, int w);
    return int'((cfg_word >> lsb) & ((32'd1 << w) - 1));
  endfunction

  task automatic push_n(int n, cyc_t c);
    for (int i = 0; i < n; i++) plan_q.push_back(c);
  endtask

  // Expand an accepted request into its expected cycles
  task automatic build_plan(logic dir, logic busy);
    cyc_t lo, hi;
    int   nlo;
    if (ce_exp) push_n(fld(24, 2) + 1, WAIT_C);
    if (have_prev && prev_dir != dir) push_n(fld(16, 3) + 1, WAIT_C);
    lo = WAIT_C; lo.we_n = dir; lo.re_n = !dir; lo.oe = !dir;
    hi = WAIT_C; hi.oe = !dir;
    nlo = dir ? fld(8, 4) + 1 : fld(0, 4) + 1;
    push_n(nlo - 1, lo);
    lo.cap = dir;
    plan_q.push_back(lo);
    push_n(dir ? fld(12, 4) + 1 : fld(4, 4) + 1, hi);
    if (busy) begin
      push_n(fld(19, 5) + 1, WAIT_C);
      plan_q.push_back(POLL_C);
    end else begin
      plan_q.push_back(DONE_C);
    end
    have_prev = 1'b1;
    prev_dir  = dir;
    ce_exp    = 1'b0;
    wd_exp    = req_wdata;
  endtask

  task automatic model_edge();
    if (cur.cap) rd_exp = nand_dq_in;
    if (cur.idle) begin
      if (op_end) begin
        ce_exp = 1'b1;
        cur = IDLE_C;
      end else if (req_valid) begin
        build_plan(req_dir, req_busy);
        cur = plan_q.pop_front();
      end else begin
        cur = IDLE_C;
      end
    end else if (cur.poll) begin
      cur = nand_rb ? DONE_C : POLL_C;
    end else begin
      cur = plan_q.pop_front();
    end
  endtask

  task automatic compare_all();
    chk(nand_ce_n === ce_exp, "R9 ce_n", nand_ce_n, ce_exp);
    chk(nand_we_n === cur.we_n, "R1 we_n", nand_we_n, cur.we_n);
    chk(nand_re_n === cur.re_n, "R2 re_n", nand_re_n, cur.re_n);
    chk(nand_dq_oe === cur.oe, "R4 dq_oe", nand_dq_oe, cur.oe);
    if (cur.oe) chk(nand_dq_out === wd_exp, "R4 dq_out", nand_dq_out, wd_exp);
    chk(xfer_done === cur.done, "R10 done", xfer_done, cur.done);
    chk(req_ready === (cur.idle && !op_end), "R11 ready", req_ready, cur.idle && !op_end);
    chk(rd_data === rd_exp, "R3 rd_data", rd_data, rd_exp);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    nand_dq_in = nand_dq_in + 8'h3B;
  endtask

  // One transfer; measures strobe latency and completion time
  task automatic issue(logic dir, logic busy, logic [7:0] wd, int rb_k,
                       string lat_tag, string done_tag);
    int lead_n, gap_n, pre, done_at, low_at, s;
    lead_n = ce_exp ? fld(24, 2) + 1 : 0;
    gap_n  = (have_prev && prev_dir != dir) ? fld(16, 3) + 1 : 0;
    pre    = lead_n + gap_n +
             (dir ? fld(8, 4) + fld(12, 4) : fld(0, 4) + fld(4, 4)) + 2 +
             (busy ? fld(19, 5) + 1 : 0);
    done_at = busy ? pre + rb_k + 1 : pre;
    req_valid = 1'b1; req_dir = dir; req_busy = busy; req_wdata = wd; nand_rb = 1'b1;
    step();
    req_valid = 1'b0;
    low_at = -1;
    s = 0;
    while (s < 4000) begin
      if (low_at < 0 && (!nand_we_n || !nand_re_n)) low_at = s;
      if (xfer_done) break;
      nand_rb = (busy && s >= pre - 2 && s < pre + rb_k) ? 1'b0 : 1'b1;
      step();
      s++;
    end
    nand_rb = 1'b1;
    chk(low_at == lead_n + gap_n, lat_tag, low_at, lead_n + gap_n);
    chk(s == done_at, done_tag, s, done_at);
  endtask

  task automatic end_op();
    op_end = 1'b1;
    step();
    op_end = 1'b0;
    chk(nand_ce_n === 1'b1, "R9 ce released by op_end", nand_ce_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_word = '0; req_valid = 1'b0; req_dir = 1'b0; req_busy = 1'b0;
    req_wdata = '0; op_end = 1'b0; nand_rb = 1'b1; nand_dq_in = 8'h11;
    cur = IDLE_C; ce_exp = 1'b1; have_prev = 1'b0; prev_dir = 1'b0;
    rd_exp = '0; wd_exp = '0;
    repeat (3) @(negedge clk);
    // R12: state while and just after reset
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe && !xfer_done,
        "R12 strobes idle in reset", {nand_ce_n, nand_we_n, nand_re_n, nand_dq_oe, xfer_done}, 5'b11100);
    chk(rd_data === 8'h00 && req_ready === 1'b1, "R12 rd_data and ready", {rd_data, req_ready}, 9'h001);
    rst_n = 1'b1;
    repeat (4) step();

    cfg_word = pack_cfg(2, 1, 3, 0, 2, 4, 1);
    issue(1'b0, 1'b0, 8'hA5, 0, "R6 lead before first strobe", "R10 done after write");
    chk(nand_ce_n === 1'b0, "R9 ce held after transfer", nand_ce_n, 0);
    issue(1'b0, 1'b0, 8'h3C, 0, "R1 write strobe immediate", "R1 write phases");
    issue(1'b1, 1'b0, 8'h00, 0, "R5 gap on direction change", "R2 read phases");
    issue(1'b1, 1'b0, 8'h00, 0, "R5 no gap same direction", "R2 read phases again");
    end_op();

    cfg_word = 32'h0;
    issue(1'b1, 1'b0, 8'h00, 0, "R6 minimal lead", "R2 minimal read");
    issue(1'b0, 1'b0, 8'h96, 0, "R5 minimal gap", "R1 minimal write");
    issue(1'b0, 1'b0, 8'h69, 0, "R1 back to back", "R10 done minimal");
    end_op();

    cfg_word = pack_cfg(15, 15, 15, 15, 7, 31, 3);
    issue(1'b0, 1'b0, 8'hF0, 0, "R6 max lead", "R1 max write");
    issue(1'b1, 1'b0, 8'h00, 0, "R5 max gap", "R2 max read");
    end_op();

    cfg_word = pack_cfg(2, 1, 3, 0, 2, 4, 1);
    issue(1'b0, 1'b1, 8'h70, 3, "R6 lead before command", "R7 busy delay then poll");
    issue(1'b0, 1'b1, 8'h80, 0, "R1 command write", "R8 ready at once after delay");
    cfg_word = pack_cfg(1, 0, 1, 0, 1, 0, 0);
    issue(1'b1, 1'b1, 8'h00, 5, "R5 gap before busy read", "R8 wait for ready");

    // R11: op_end and a request in the same idle cycle
    op_end = 1'b1; req_valid = 1'b1; req_dir = 1'b0; req_busy = 1'b0; req_wdata = 8'h5A;
    #1;
    chk(req_ready === 1'b0, "R11 op_end masks ready", req_ready, 0);
    step();
    op_end = 1'b0; req_valid = 1'b0;
    chk(nand_ce_n === 1'b1, "R11 ce released on collision", nand_ce_n, 1);
    issue(1'b0, 1'b0, 8'h5A, 0, "R11 fresh lead after collision", "R10 done after collision");
    end_op();
    repeat (3) step();

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule